// File: doc/BRIEF.md
# Single-Channel Block DMA Controller

The block moves a programmed number of bytes between a synchronous byte-wide memory and one peripheral, one byte at a time. Software sets up a block through a four-word register port: a transfer count, a memory pointer and a control word that selects the direction and the interrupt enable. A final control write with the start bit set begins the block. Each byte is moved only after the peripheral asks for it. The controller then wins the shared bus through a request/grant handshake, performs one memory access, and hands the bus back before it looks for the next request.

When the count reaches zero the controller raises a done flag, and an interrupt if one is enabled. This happens once per block. Software acknowledges it by writing one to the done bit of the status word. A block programmed with a count of zero completes at once and does not touch the bus.

The sequencer has six named states:
- IDLE goes to WAIT_REQ on start, or to DONE on start when the count is zero.
- WAIT_REQ goes to BUS_REQ on an armed peripheral request.
- BUS_REQ goes to XFER on grant.
- XFER always goes to RELEASE.
- RELEASE goes to DONE when the grant is gone and the count is zero. It goes to WAIT_REQ when the grant is gone and bytes remain.
- DONE always goes to IDLE.

Top module: `blk_dma_ctrl`

## Requirements
- R1: After reset every register reads 0, and bus_req, mem_en, dev_ack and irq are low. The register offsets are: 0 = count, 1 = memory pointer, 2 = control, 3 = status.
- R2: A write to offset 2 with bit0 = 1 while idle starts a block. In that write, bit1 selects the direction (0 = memory to peripheral, 1 = peripheral to memory) and bit2 enables the interrupt. Control reads back bit1 and bit2, and bit0 reads 0. Status bit1 reads 1 while a block is in progress.
- R3: A byte transfer begins only on dev_req. After an acknowledge, dev_req must be seen low for at least one clock before another request is taken.
- R4: Before any memory access the controller raises bus_req and waits for bus_gnt. mem_en is never high without bus_gnt.
- R5: In direction 0, the byte at the pointer is read and presented on dev_out_data during a single-cycle dev_ack pulse.
- R6: In direction 1, dev_in_data is written to memory at the pointer.
- R7: Each moved byte decrements the count by one and increments the pointer by one.
- R8: bus_req drops after every byte, in the same cycle that dev_ack pulses, even when bytes remain. The controller waits for bus_gnt to fall before it continues.
- R9: When the count reaches zero, status bit0 (done) is set exactly once per block. irq is also set if the interrupt was enabled.
- R10: Writing offset 3 with bit0 = 1 clears both done and irq.
- R11: While a block is in progress, writes to offsets 0, 1 and 2 are ignored.
- R12: Starting with a count of zero sets done without any bus request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_sel | input | 1 | Register port select |
| cpu_wr | input | 1 | Register write strobe (qualified by cpu_sel) |
| cpu_addr | input | 2 | Register offset |
| cpu_wdata | input | 16 | Register write data |
| cpu_rdata | output | 16 | Register read data (combinational) |
| dev_req | input | 1 | Peripheral transfer request |
| dev_ack | output | 1 | One-cycle acknowledge of a moved byte |
| dev_in_data | input | 8 | Byte offered by the peripheral |
| dev_out_data | output | 8 | Byte delivered to the peripheral, valid with dev_ack |
| bus_req | output | 1 | Shared bus request |
| bus_gnt | input | 1 | Shared bus grant |
| mem_en | output | 1 | Memory access enable |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | 16 | Memory address |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data, one cycle after the access |
| irq | output | 1 | Block-complete interrupt |

## Verification
The assertions assume three things about the inputs:
- The bus arbiter keeps bus_gnt high for as long as bus_req is high once it has granted, and it removes the grant only after the request drops.
- The peripheral holds dev_req and dev_in_data steady until it sees dev_ack.
- Memory read data is valid in the cycle after the access and stays valid until the next one.

The bench's arbiter model grants two cycles after a request and follows a dropped request with a one-cycle lag. Its peripheral task raises a request and holds it until the acknowledge, and in one case holds it well past the acknowledge to check the rearm rule.

// File: rtl/blk_dma_pkg.sv
package blk_dma_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_WAIT_REQ,
        S_BUS_REQ,
        S_XFER,
        S_RELEASE,
        S_DONE
    } dma_state_e;

    localparam logic [1:0] OFS_COUNT = 2'd0;
    localparam logic [1:0] OFS_PTR   = 2'd1;
    localparam logic [1:0] OFS_CTRL  = 2'd2;
    localparam logic [1:0] OFS_STAT  = 2'd3;

    localparam int CTRL_GO_BIT  = 0;
    localparam int CTRL_DIR_BIT = 1;
    localparam int CTRL_IE_BIT  = 2;

    localparam int STAT_DONE_BIT = 0;
    localparam int STAT_BUSY_BIT = 1;

endpackage

// File: rtl/blk_dma_req_gate.sv
module blk_dma_req_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic dev_req,
    input  logic step,
    output logic req_ok
);

    logic armed_q;

    // A request counts again only once it has been seen low after a transfer.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            armed_q <= 1'b1;
        end else if (step) begin
            armed_q <= 1'b0;
        end else if (!dev_req) begin
            armed_q <= 1'b1;
        end
    end

    assign req_ok = dev_req & armed_q;

endmodule

// File: rtl/blk_dma_regs.sv
module blk_dma_regs
    import blk_dma_pkg::*;
#(
    parameter int REG_W  = 16,
    parameter int CNT_W  = 16,
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_sel,
    input  logic              cpu_wr,
    input  logic [1:0]        cpu_addr,
    input  logic [REG_W-1:0]  cpu_wdata,
    output logic [REG_W-1:0]  cpu_rdata,
    input  logic              busy,
    input  logic              step,
    input  logic              finish,
    output logic              start_req,
    output logic              count_zero,
    output logic [ADDR_W-1:0] cur_addr,
    output logic              dir,
    output logic              irq
);

    localparam logic [CNT_W-1:0]  CNT_ONE  = CNT_W'(1);
    localparam logic [ADDR_W-1:0] ADDR_ONE = ADDR_W'(1);

    logic [CNT_W-1:0]  count_q;
    logic [ADDR_W-1:0] addr_q;
    logic              dir_q;
    logic              ie_q;
    logic              done_q;
    logic              irq_q;
    logic              wr_en;
    logic              cfg_wr;

    assign wr_en  = cpu_sel & cpu_wr;
    // Configuration writes are accepted only while idle.
    assign cfg_wr = wr_en & ~busy;

    assign start_req  = cfg_wr && (cpu_addr == OFS_CTRL) && cpu_wdata[CTRL_GO_BIT];
    assign count_zero = (count_q == '0);
    assign cur_addr   = addr_q;
    assign dir        = dir_q;
    assign irq        = irq_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= '0;
            addr_q  <= '0;
        end else if (cfg_wr && cpu_addr == OFS_COUNT) begin
            count_q <= cpu_wdata[CNT_W-1:0];
        end else if (cfg_wr && cpu_addr == OFS_PTR) begin
            addr_q <= cpu_wdata[ADDR_W-1:0];
        end else if (step) begin
            count_q <= count_q - CNT_ONE;
            addr_q  <= addr_q + ADDR_ONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_q <= 1'b0;
            ie_q  <= 1'b0;
        end else if (cfg_wr && cpu_addr == OFS_CTRL) begin
            dir_q <= cpu_wdata[CTRL_DIR_BIT];
            ie_q  <= cpu_wdata[CTRL_IE_BIT];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done_q <= 1'b0;
            irq_q  <= 1'b0;
        end else if (finish) begin
            done_q <= 1'b1;
            irq_q  <= ie_q;
        end else if (wr_en && cpu_addr == OFS_STAT && cpu_wdata[STAT_DONE_BIT]) begin
            done_q <= 1'b0;
            irq_q  <= 1'b0;
        end
    end

    always_comb begin
        cpu_rdata = '0;
        unique case (cpu_addr)
            OFS_COUNT: cpu_rdata = REG_W'(count_q);
            OFS_PTR:   cpu_rdata = REG_W'(addr_q);
            OFS_CTRL: begin
                cpu_rdata[CTRL_DIR_BIT] = dir_q;
                cpu_rdata[CTRL_IE_BIT]  = ie_q;
            end
            OFS_STAT: begin
                cpu_rdata[STAT_DONE_BIT] = done_q;
                cpu_rdata[STAT_BUSY_BIT] = busy;
            end
            default: cpu_rdata = '0;
        endcase
    end

    // R7
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> (count_q == $past(count_q) - CNT_ONE) && (addr_q == $past(addr_q) + ADDR_ONE));

    // R11
    busy_cfg_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && wr_en && !step && cpu_addr != OFS_STAT) |=> $stable(count_q) && $stable(addr_q) && $stable(dir_q) && $stable(ie_q));

    // R9
    done_on_finish_chk: assert property (@(posedge clk) disable iff (!rst_n)
        finish |=> done_q && (irq_q == $past(ie_q)));

    // R10
    w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && cpu_addr == OFS_STAT && cpu_wdata[STAT_DONE_BIT] && !finish) |=> !done_q && !irq_q);

endmodule

// File: rtl/blk_dma_seq.sv
module blk_dma_seq
    import blk_dma_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_req,
    input  logic count_zero,
    input  logic req_ok,
    input  logic bus_gnt,
    output logic bus_req,
    output logic mem_en,
    output logic step,
    output logic finish,
    output logic busy,
    output logic ack
);

    dma_state_e state_q;
    dma_state_e state_d;
    logic       ack_q;

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // The acknowledge follows the access by one cycle, when read data is valid.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ack_q <= 1'b0;
        end else begin
            ack_q <= (state_q == S_XFER);
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (start_req) begin
                    state_d = count_zero ? S_DONE : S_WAIT_REQ;
                end
            end
            S_WAIT_REQ: begin
                if (req_ok) begin
                    state_d = S_BUS_REQ;
                end
            end
            S_BUS_REQ: begin
                if (bus_gnt) begin
                    state_d = S_XFER;
                end
            end
            S_XFER: begin
                state_d = S_RELEASE;
            end
            S_RELEASE: begin
                if (!bus_gnt) begin
                    state_d = count_zero ? S_DONE : S_WAIT_REQ;
                end
            end
            S_DONE: begin
                state_d = S_IDLE;
            end
            default: state_d = S_IDLE;
        endcase
    end

    // Outputs.
    always_comb begin
        bus_req = 1'b0;
        mem_en  = 1'b0;
        step    = 1'b0;
        finish  = 1'b0;
        busy    = 1'b1;
        unique case (state_q)
            S_IDLE:     busy = 1'b0;
            S_WAIT_REQ: ;
            S_BUS_REQ:  bus_req = 1'b1;
            S_XFER: begin
                bus_req = 1'b1;
                mem_en  = 1'b1;
                step    = 1'b1;
            end
            S_RELEASE:  ;
            S_DONE:     finish = 1'b1;
            default:    busy = 1'b0;
        endcase
    end

    assign ack = ack_q;

    // R3
    wait_for_request_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_WAIT_REQ && !req_ok) |=> state_q == S_WAIT_REQ);

    // R4
    grant_held_in_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_XFER) |-> bus_gnt);

    // R5
    ack_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack_q |=> !ack_q);

    // R8
    release_drops_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_RELEASE && bus_gnt) |=> state_q == S_RELEASE);

    // R9
    done_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_DONE) |=> state_q == S_IDLE);

    // R12
    zero_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_IDLE && start_req && count_zero) |=> state_q == S_DONE);

endmodule

// File: rtl/blk_dma_ctrl.sv
module blk_dma_ctrl #(
    parameter int REG_W  = 16,
    parameter int CNT_W  = 16,
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_sel,
    input  logic              cpu_wr,
    input  logic [1:0]        cpu_addr,
    input  logic [REG_W-1:0]  cpu_wdata,
    output logic [REG_W-1:0]  cpu_rdata,
    input  logic              dev_req,
    output logic              dev_ack,
    input  logic [DATA_W-1:0] dev_in_data,
    output logic [DATA_W-1:0] dev_out_data,
    output logic              bus_req,
    input  logic              bus_gnt,
    output logic              mem_en,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              irq
);

    logic start_req;
    logic count_zero;
    logic req_ok;
    logic step;
    logic finish;
    logic busy;
    logic dir;
    logic ack;
    logic [ADDR_W-1:0] cur_addr;

    blk_dma_regs #(
        .REG_W  (REG_W),
        .CNT_W  (CNT_W),
        .ADDR_W (ADDR_W)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .cpu_sel    (cpu_sel),
        .cpu_wr     (cpu_wr),
        .cpu_addr   (cpu_addr),
        .cpu_wdata  (cpu_wdata),
        .cpu_rdata  (cpu_rdata),
        .busy       (busy),
        .step       (step),
        .finish     (finish),
        .start_req  (start_req),
        .count_zero (count_zero),
        .cur_addr   (cur_addr),
        .dir        (dir),
        .irq        (irq)
    );

    blk_dma_req_gate u_gate (
        .clk     (clk),
        .rst_n   (rst_n),
        .dev_req (dev_req),
        .step    (step),
        .req_ok  (req_ok)
    );

    blk_dma_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_req  (start_req),
        .count_zero (count_zero),
        .req_ok     (req_ok),
        .bus_gnt    (bus_gnt),
        .bus_req    (bus_req),
        .mem_en     (mem_en),
        .step       (step),
        .finish     (finish),
        .busy       (busy),
        .ack        (ack)
    );

    // Datapath: memory side driven during the access, peripheral side during the acknowledge.
    assign mem_addr     = cur_addr;
    assign mem_we       = mem_en & dir;
    assign mem_wdata    = dev_in_data;
    assign dev_ack      = ack;
    assign dev_out_data = ack ? mem_rdata : '0;

    // R4
    access_needs_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_en |-> bus_gnt);

    // R8
    ack_at_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dev_ack |-> !bus_req && $fell(bus_req));

    // R12
    no_bus_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !bus_req && !mem_en);

endmodule

// File: tb/test_blk_dma_ctrl.sv
`timescale 1ns/1ps
module test_blk_dma_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_sel = 1'b0;
    logic        cpu_wr = 1'b0;
    logic [1:0]  cpu_addr = 2'd0;
    logic [15:0] cpu_wdata = 16'd0;
    logic [15:0] cpu_rdata;
    logic        dev_req = 1'b0;
    logic        dev_ack;
    logic [7:0]  dev_in_data = 8'd0;
    logic [7:0]  dev_out_data;
    logic        bus_req;
    logic        bus_gnt;
    logic        mem_en;
    logic        mem_we;
    logic [15:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata;
    logic        irq;

    int checks = 0;
    int errors = 0;
    int breq_rises = 0;
    int irq_rises = 0;
    logic cur_dir = 1'b0;
    logic [24:0] exp_q[$];
    logic [7:0] mem [256];
    logic gnt_d;
    logic breq_prev, irq_prev;

    always #10 clk = ~clk;

    blk_dma_ctrl i_blk_dma_ctrl (
        .clk(clk), .rst_n(rst_n), .cpu_sel(cpu_sel), .cpu_wr(cpu_wr),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .dev_req(dev_req), .dev_ack(dev_ack), .dev_in_data(dev_in_data),
        .dev_out_data(dev_out_data), .bus_req(bus_req), .bus_gnt(bus_gnt),
        .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .irq(irq)
    );

    // Synchronous memory model.
    always @(posedge clk) begin
        if (mem_en) begin
            if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
            else        mem_rdata <= mem[mem_addr[7:0]];
        end
    end

    // Arbiter model: grant two cycles after request, drop one cycle after release.
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gnt_d   <= 1'b0;
            bus_gnt <= 1'b0;
        end else begin
            gnt_d   <= bus_req;
            bus_gnt <= gnt_d & bus_req;
        end
    end

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            breq_prev <= 1'b0;
            irq_prev  <= 1'b0;
        end else begin
            breq_prev <= bus_req;
            irq_prev  <= irq;
            if (bus_req && !breq_prev) breq_rises <= breq_rises + 1;
            if (irq && !irq_prev)      irq_rises  <= irq_rises + 1;
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Scoreboard monitor: bit24 = 1 memory write {addr,data}, 0 byte to peripheral.
    always @(negedge clk) begin
        if (rst_n && mem_en && mem_we) begin
            if (exp_q.size() == 0) check(1'b0, "R6 unexpected write", {mem_addr, mem_wdata}, 0);
            else begin
                logic [24:0] it;
                it = exp_q.pop_front();
                check(it[24] && it[23:0] == {mem_addr, mem_wdata}, "R6 memory write",
                      {mem_addr, mem_wdata}, it[23:0]);
            end
        end
        if (rst_n && dev_ack && !cur_dir) begin
            if (exp_q.size() == 0) check(1'b0, "R5 unexpected byte", dev_out_data, 0);
            else begin
                logic [24:0] it;
                it = exp_q.pop_front();
                check(!it[24] && it[7:0] == dev_out_data, "R5 byte to peripheral",
                      dev_out_data, it[7:0]);
            end
        end
    end

    task automatic cpu_write(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        cpu_sel = 1'b1; cpu_wr = 1'b1; cpu_addr = a; cpu_wdata = d;
        @(negedge clk);
        cpu_sel = 1'b0; cpu_wr = 1'b0;
    endtask

    task automatic cpu_read(input logic [1:0] a, output logic [15:0] d);
        @(negedge clk);
        cpu_addr = a;
        #1 d = cpu_rdata;
    endtask

    task automatic dev_unit(input logic [7:0] d);
        @(negedge clk);
        dev_in_data = d;
        dev_req = 1'b1;
        do @(negedge clk); while (!dev_ack);
        dev_req = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic wait_done();
        logic [15:0] s;
        for (int i = 0; i < 500; i++) begin
            cpu_read(2'd3, s);
            if (s[0]) break;
        end
    endtask

    // Driver: pushes expected items, programs and runs one block.
    task automatic run_block(input logic dir, input logic ie, input logic [15:0] start, input int n);
        cur_dir = dir;
        for (int i = 0; i < n; i++) begin
            if (dir) exp_q.push_back({1'b1, start + 16'(i), 8'(8'hA0 + i)});
            else     exp_q.push_back({1'b0, 16'h0, mem[8'(start) + 8'(i)]});
        end
        cpu_write(2'd0, 16'(n));
        cpu_write(2'd1, start);
        cpu_write(2'd2, {13'd0, ie, dir, 1'b1});
        for (int i = 0; i < n; i++) dev_unit(8'(8'hA0 + i));
        wait_done();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [15:0] r;
        int snap;
        for (int i = 0; i < 256; i++) mem[i] = 8'(i * 7 + 3);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        for (int a = 0; a < 4; a++) begin
            cpu_read(2'(a), r);
            check(r == 16'd0, "R1 register reset", r, 0);
        end
        check(!bus_req && !mem_en && !dev_ack && !irq, "R1 outputs reset",
              {bus_req, mem_en, dev_ack, irq}, 0);

        // Direction 0 block, interrupt enabled
        run_block(1'b0, 1'b1, 16'h0010, 4);
        cpu_read(2'd0, r); check(r == 16'd0, "R7 count at end", r, 0);
        cpu_read(2'd1, r); check(r == 16'h0014, "R7 pointer at end", r, 16'h0014);
        cpu_read(2'd3, r); check(r == 16'd1, "R9 done and not busy", r, 1);
        check(irq == 1'b1, "R9 irq with enable", irq, 1);
        check(breq_rises == 4, "R8 bus released per byte", breq_rises, 4);
        check(irq_rises == 1, "R9 single completion", irq_rises, 1);
        check(exp_q.size() == 0, "R5 all bytes delivered", exp_q.size(), 0);
        cpu_read(2'd2, r); check(r == 16'd4, "R2 control readback", r, 4);

        // R10 acknowledge
        cpu_write(2'd3, 16'd1);
        cpu_read(2'd3, r); check(r == 16'd0, "R10 done cleared", r, 0);
        check(irq == 1'b0, "R10 irq cleared", irq, 0);

        // Direction 1 block, interrupt disabled
        run_block(1'b1, 1'b0, 16'h0040, 3);
        cpu_read(2'd3, r); check(r == 16'd1, "R9 done without enable", r, 1);
        check(irq == 1'b0, "R9 no irq when disabled", irq, 0);
        check(mem[8'h42] == 8'hA2, "R6 memory content", mem[8'h42], 8'hA2);
        cpu_read(2'd1, r); check(r == 16'h0043, "R7 pointer after write block", r, 16'h0043);
        check(exp_q.size() == 0, "R6 all writes seen", exp_q.size(), 0);
        cpu_write(2'd3, 16'd1);

        // Busy block: ignored writes and request rearm
        cur_dir = 1'b0;
        exp_q.push_back({1'b0, 16'h0, mem[8'h20]});
        exp_q.push_back({1'b0, 16'h0, mem[8'h21]});
        cpu_write(2'd0, 16'd2);
        cpu_write(2'd1, 16'h0020);
        cpu_write(2'd2, 16'h0005);
        snap = breq_rises;
        cpu_read(2'd3, r); check(r == 16'd2, "R2 busy flag", r, 2);
        cpu_write(2'd0, 16'h0055);
        cpu_write(2'd1, 16'h0099);
        cpu_write(2'd2, 16'h0002);
        cpu_read(2'd0, r); check(r == 16'd2, "R11 count write ignored", r, 2);
        cpu_read(2'd1, r); check(r == 16'h0020, "R11 pointer write ignored", r, 16'h0020);
        cpu_read(2'd2, r); check(r == 16'd4, "R11 control write ignored", r, 4);
        check(breq_rises == snap, "R3 no bus request without dev_req", breq_rises, snap);
        @(negedge clk);
        dev_req = 1'b1;
        do @(negedge clk); while (!dev_ack);
        repeat (20) @(negedge clk);
        check(breq_rises == snap + 1, "R3 held request not recounted", breq_rises, snap + 1);
        cpu_read(2'd0, r); check(r == 16'd1, "R3 count after one byte", r, 1);
        dev_req = 1'b0;
        repeat (2) @(negedge clk);
        dev_unit(8'h00);
        wait_done();
        cpu_read(2'd3, r); check(r == 16'd1, "R9 done after rearmed block", r, 1);
        check(exp_q.size() == 0, "R5 rearmed bytes delivered", exp_q.size(), 0);

        // R12 zero-count start
        cpu_write(2'd3, 16'd1);
        snap = breq_rises;
        cpu_write(2'd0, 16'd0);
        cpu_write(2'd2, 16'h0005);
        wait_done();
        cpu_read(2'd3, r); check(r == 16'd1, "R12 done at once", r, 1);
        check(breq_rises == snap, "R12 no bus cycles", breq_rises, snap);
        check(irq == 1'b1, "R12 irq with enable", irq, 1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule